// File: doc/BRIEF.md
# Successive-Integration Conversion Sequencer

This block is the digital control core of an integrating converter that refines a dual-slope reading by successive integration of the residue. It runs on the oscillator clock. It derives a slower conversion clock from it and steps through a fixed cycle. The cycle integrates the input for a set time, then runs three de-integrate phases, each ended by the zero-crossing comparator. A rest phase and a times-ten residue amplification phase sit between the de-integrate phases. While it does so it drives the analog switch enables and tells an external up/down results counter when to count and in which direction.

After the input pass the same sequence is repeated with the inputs shorted. The count directions are reversed in this offset pass, so the results counter ends up holding the input reading minus the offset reading. A zero-integrate phase and a latch phase close the conversion, and the active-low latch strobe marks the final clocks in which the counter value is valid. A de-integrate phase that never sees a crossing is cut off by a timeout, and the conversion carries on with an over-range flag raised. The analog integrator is not part of the block.

Top module: `si_phase_seq`

## Requirements
- R1: Each pass runs integrate, DE1, rest, x10, DE2, rest, x10, DE3. The input pass (offset_pass=0) comes first, then the offset pass (offset_pass=1), then the zero-integrate phase, then the latch phase, and the cycle repeats. That is six de-integrate phases per conversion.
- R2: The integrate phase of both passes lasts INT_LEN_HI conversion clocks when range_hi was 1, or INT_LEN_LO clocks when it was 0. range_hi is sampled only when the latch phase ends. A change of range_hi during a conversion has no effect on that conversion.
- R3: One conversion clock is OSC_DIV oscillator (clk) cycles. In a de-integrate phase cnt_en is high for exactly one clk cycle per conversion clock, and it is low outside de-integrate phases.
- R4: A de-integrate phase ends on the conversion clock at which cmp_zero is sampled high, and that clock is counted. A phase whose crossing comes after N conversion clocks therefore gives exactly N cnt_en pulses.
- R5: cnt_up=1 means count up. In the input pass DE1 and DE3 count up and DE2 counts down; in the offset pass DE1 and DE3 count down and DE2 counts up. offset_pass is 0 while sw_int1 is high and 1 while sw_int2 is high.
- R6: A de-integrate phase without a crossing ends after DE_TIMEOUT conversion clocks and sets ovr_flag. A crossing on that same last clock wins, and then ovr_flag is not set. ovr_flag stays set through the latch phase and clears when the next conversion starts.
- R7: in_pos is sampled on the last clock of each integrate phase. In every de-integrate phase of that pass sw_de_pos equals the sample and sw_de_neg its inverse. Both are 0 outside de-integrate phases.
- R8: sw_int is low exactly during integrate phases, sw_int1 during the input-pass integrate and sw_int2 during the offset-pass integrate. sw_de is low exactly during de-integrate phases. At most one of sw_zi, sw_int1, sw_int2, not sw_de, sw_rest, sw_x10 and not latch_n is high at any time.
- R9: Every rest phase lasts REST_LEN conversion clocks, every x10 phase X10_LEN clocks, and the zero-integrate phase ZI_LEN clocks.
- R10: latch_n is low for exactly the final LATCH_LEN conversion clocks of each conversion.
- R11: While rst_n is low the block is in the zero-integrate phase of the input pass: sw_zi=1, sw_int=1, sw_de=1, cnt_en=0, latch_n=1, ovr_flag=0, offset_pass=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_hi | input | 1 | 1 selects the short (high-range) integrate length |
| in_pos | input | 1 | Polarity of the integrated signal, 1 for positive |
| cmp_zero | input | 1 | Zero-crossing comparator, high once the integrator has crossed |
| sw_zi | output | 1 | Zero-integrate switch enable |
| sw_int1 | output | 1 | Input-pass integrate switch enable |
| sw_int2 | output | 1 | Offset-pass (shorted input) integrate switch enable |
| sw_int | output | 1 | Switch that is open (low) during both integrate phases |
| sw_de | output | 1 | Switch that is open (low) during all de-integrate phases |
| sw_de_pos | output | 1 | De-integrate reference switch for positive input |
| sw_de_neg | output | 1 | De-integrate reference switch for negative input |
| sw_rest | output | 1 | Rest-phase switch enable |
| sw_x10 | output | 1 | Residue times-ten amplification switch enable |
| cnt_en | output | 1 | Results counter count enable, one pulse per conversion clock |
| cnt_up | output | 1 | Results counter direction, 1 counts up |
| offset_pass | output | 1 | 1 during the shorted-input offset pass |
| ovr_flag | output | 1 | A de-integrate phase timed out in this conversion |
| latch_n | output | 1 | Active-low latch strobe for the final clocks of the conversion |

## Verification
Two functions can fall on the same conversion clock: a comparator crossing and the expiry of the de-integrate timeout. Only one may decide the phase end. The bench provokes this with a crossing placed on exactly the DE_TIMEOUT-th clock of DE1. It expects the phase to count DE_TIMEOUT pulses and ovr_flag to stay low at the latch. A neighbouring vector whose DE1 never crosses must raise the flag with the same pulse count, and the conversion after it must show the flag cleared.

// File: rtl/sis_pkg.sv
package sis_pkg;

   typedef enum logic [3:0] {
      PH_ZI    = 4'd0,
      PH_INT   = 4'd1,
      PH_DE1   = 4'd2,
      PH_REST1 = 4'd3,
      PH_X10A  = 4'd4,
      PH_DE2   = 4'd5,
      PH_REST2 = 4'd6,
      PH_X10B  = 4'd7,
      PH_DE3   = 4'd8,
      PH_LATCH = 4'd9
   } sis_phase_e;

   function automatic int sis_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sis_clk_div.sv
module sis_clk_div #(
   parameter int OSC_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (OSC_DIV == 1) begin : g_direct
         // every oscillator cycle is a conversion clock
         assign tick = 1'b1;
      end else begin : g_count
         localparam int DW = $clog2(OSC_DIV);
         localparam logic [DW-1:0] LAST = DW'(OSC_DIV - 1);
         logic [DW-1:0] dcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            dcnt <= '0;
            else if (dcnt == LAST) dcnt <= '0;
            else                   dcnt <= dcnt + 1'b1;
         end

         assign tick = (dcnt == LAST);

         // R3: conversion clock enables never come back to back
         a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/sis_phase_timer.sv
module sis_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          done,
   output logic [CW-1:0] count
);

   // counts conversion clocks spent in the current phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (done)  count <= '0;
      else if (tick)  count <= count + 1'b1;
   end

endmodule

// File: rtl/sis_phase_fsm.sv
module sis_phase_fsm
   import sis_pkg::*;
#(
   parameter int INT_LEN_HI = 1000,
   parameter int INT_LEN_LO = 10000,
   parameter int REST_LEN   = 100,
   parameter int X10_LEN    = 100,
   parameter int ZI_LEN     = 100,
   parameter int LATCH_LEN  = 100,
   parameter int DE_TIMEOUT = 20000,
   parameter int CW         = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          range_hi,
   input  logic          in_pos,
   input  logic          cmp_zero,
   input  logic [CW-1:0] tcnt,
   output logic          done,
   output sis_phase_e    phase,
   output logic          pass,
   output logic          pol,
   output logic          ovr
);

   logic [CW-1:0] len;
   logic          is_de;
   logic          last_clk;
   sis_phase_e    nxt;
   logic          rng_q;

   always_comb begin
      is_de = (phase == PH_DE1) || (phase == PH_DE2) || (phase == PH_DE3);
      unique case (phase)
         PH_ZI:              len = CW'(ZI_LEN);
         PH_INT:             len = rng_q ? CW'(INT_LEN_HI) : CW'(INT_LEN_LO);
         PH_REST1, PH_REST2: len = CW'(REST_LEN);
         PH_X10A, PH_X10B:   len = CW'(X10_LEN);
         PH_LATCH:           len = CW'(LATCH_LEN);
         default:            len = CW'(DE_TIMEOUT);
      endcase
      last_clk = (tcnt == len - CW'(1));
      done     = tick && (is_de ? (cmp_zero || last_clk) : last_clk);
   end

   always_comb begin
      unique case (phase)
         PH_ZI:    nxt = PH_LATCH;
         PH_LATCH: nxt = PH_INT;
         PH_INT:   nxt = PH_DE1;
         PH_DE1:   nxt = PH_REST1;
         PH_REST1: nxt = PH_X10A;
         PH_X10A:  nxt = PH_DE2;
         PH_DE2:   nxt = PH_REST2;
         PH_REST2: nxt = PH_X10B;
         PH_X10B:  nxt = PH_DE3;
         PH_DE3:   nxt = pass ? PH_ZI : PH_INT;
         default:  nxt = PH_ZI;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_ZI;
         pass  <= 1'b0;
         pol   <= 1'b1;
         rng_q <= 1'b1;
         ovr   <= 1'b0;
      end else if (done) begin
         phase <= nxt;
         if (phase == PH_LATCH) begin
            pass  <= 1'b0;
            rng_q <= range_hi;
            ovr   <= 1'b0;
         end
         if (phase == PH_INT) pol <= in_pos;
         if (phase == PH_DE3) pass <= 1'b1;
         if (is_de && !cmp_zero) ovr <= 1'b1;
      end
   end

   // R4: a sampled crossing always closes the de-integrate phase
   a_r4_cross_ends_de: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && is_de && cmp_zero) |=> (phase != $past(phase)));

   // R6: running out of time raises the over-range flag
   a_r6_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && is_de && !cmp_zero && last_clk) |=> ovr);

   // R6: a new conversion starts with the flag clear
   a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INT && $past(phase) == PH_LATCH) |-> !ovr);

   // R2: the range choice only moves at the conversion boundary
   a_r2_range_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_LATCH) |=> $stable(rng_q));

   // R1: input pass hands over to the offset pass
   a_r1_pass_order: assert property (@(posedge clk) disable iff (!rst_n)
      (done && phase == PH_DE3 && !pass) |=> (phase == PH_INT && pass));

endmodule

// File: rtl/sis_switch_dec.sv
module sis_switch_dec
   import sis_pkg::*;
(
   input  sis_phase_e phase,
   input  logic       pass,
   input  logic       pol,
   input  logic       tick,
   output logic       sw_zi,
   output logic       sw_int1,
   output logic       sw_int2,
   output logic       sw_int,
   output logic       sw_de,
   output logic       sw_de_pos,
   output logic       sw_de_neg,
   output logic       sw_rest,
   output logic       sw_x10,
   output logic       cnt_en,
   output logic       cnt_up,
   output logic       latch_n
);

   logic in_de;
   logic in_int;

   always_comb begin
      in_de     = (phase == PH_DE1) || (phase == PH_DE2) || (phase == PH_DE3);
      in_int    = (phase == PH_INT);
      sw_zi     = (phase == PH_ZI);
      sw_int1   = in_int && !pass;
      sw_int2   = in_int && pass;
      sw_int    = !in_int;
      sw_de     = !in_de;
      sw_de_pos = in_de && pol;
      sw_de_neg = in_de && !pol;
      sw_rest   = (phase == PH_REST1) || (phase == PH_REST2);
      sw_x10    = (phase == PH_X10A) || (phase == PH_X10B);
      cnt_en    = in_de && tick;
      // middle phase counts against the outer two; offset pass flips all
      cnt_up    = in_de && ((phase == PH_DE2) == pass);
      latch_n   = (phase != PH_LATCH);
   end

endmodule

// File: rtl/si_phase_seq.sv
module si_phase_seq
   import sis_pkg::*;
#(
   parameter int OSC_DIV    = 2,
   parameter int INT_LEN_HI = 1000,
   parameter int INT_LEN_LO = 10000,
   parameter int REST_LEN   = 100,
   parameter int X10_LEN    = 100,
   parameter int ZI_LEN     = 100,
   parameter int LATCH_LEN  = 100,
   parameter int DE_TIMEOUT = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic range_hi,
   input  logic in_pos,
   input  logic cmp_zero,
   output logic sw_zi,
   output logic sw_int1,
   output logic sw_int2,
   output logic sw_int,
   output logic sw_de,
   output logic sw_de_pos,
   output logic sw_de_neg,
   output logic sw_rest,
   output logic sw_x10,
   output logic cnt_en,
   output logic cnt_up,
   output logic offset_pass,
   output logic ovr_flag,
   output logic latch_n
);

   localparam int MAX_LEN = sis_max(sis_max(sis_max(INT_LEN_HI, INT_LEN_LO),
                                            sis_max(REST_LEN, X10_LEN)),
                                    sis_max(sis_max(ZI_LEN, LATCH_LEN), DE_TIMEOUT));
   localparam int CW = $clog2(MAX_LEN + 1);

   generate
      if (OSC_DIV < 1) begin : g_bad_div
         $error("OSC_DIV must be at least 1");
      end
      if (INT_LEN_HI < 1 || INT_LEN_LO < 1 || REST_LEN < 1 || X10_LEN < 1 ||
          ZI_LEN < 1 || LATCH_LEN < 1 || DE_TIMEOUT < 1) begin : g_bad_len
         $error("every phase length must be at least one conversion clock");
      end
   endgenerate

   logic          tick;
   logic          done;
   logic [CW-1:0] tcnt;
   sis_phase_e    phase;
   logic          pass;
   logic          pol;

   sis_clk_div #(.OSC_DIV(OSC_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   sis_phase_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .done  (done),
      .count (tcnt)
   );

   sis_phase_fsm #(
      .INT_LEN_HI (INT_LEN_HI),
      .INT_LEN_LO (INT_LEN_LO),
      .REST_LEN   (REST_LEN),
      .X10_LEN    (X10_LEN),
      .ZI_LEN     (ZI_LEN),
      .LATCH_LEN  (LATCH_LEN),
      .DE_TIMEOUT (DE_TIMEOUT),
      .CW         (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .range_hi (range_hi),
      .in_pos   (in_pos),
      .cmp_zero (cmp_zero),
      .tcnt     (tcnt),
      .done     (done),
      .phase    (phase),
      .pass     (pass),
      .pol      (pol),
      .ovr      (ovr_flag)
   );

   sis_switch_dec u_dec (
      .phase     (phase),
      .pass      (pass),
      .pol       (pol),
      .tick      (tick),
      .sw_zi     (sw_zi),
      .sw_int1   (sw_int1),
      .sw_int2   (sw_int2),
      .sw_int    (sw_int),
      .sw_de     (sw_de),
      .sw_de_pos (sw_de_pos),
      .sw_de_neg (sw_de_neg),
      .sw_rest   (sw_rest),
      .sw_x10    (sw_x10),
      .cnt_en    (cnt_en),
      .cnt_up    (cnt_up),
      .latch_n   (latch_n)
   );

   assign offset_pass = pass;

   // R8: the phase-marking enables never overlap
   a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_zi, sw_int1, sw_int2, ~sw_de, sw_rest, sw_x10, ~latch_n}));

   // R8: the integrate path opens only with one of the integrate enables
   a_r8_int_path: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_int |-> (sw_int1 || sw_int2));

   // R7: never both reference polarities at once
   a_r7_pol_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_de_pos && sw_de_neg));

   // R10: the strobe only moves on conversion clock boundaries
   a_r10_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(latch_n));

endmodule

// File: tb/test_si_phase_seq.sv
module test_si_phase_seq;

   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 2;
   localparam int IHI   = 10;
   localparam int ILO   = 40;
   localparam int RST_L = 4;
   localparam int X10_L = 3;
   localparam int ZI_L  = 5;
   localparam int LAT_L = 6;
   localparam int TO    = 30;
   localparam int WD_CYC = 100000;
   localparam int NV = 6;

   // {range_hi, in_pos, six crossing positions}; 0 = never crosses
   localparam logic [49:0] VEC [0:NV-1] = '{
      {1'b1, 1'b1, 8'd7,  8'd3, 8'd5, 8'd2, 8'd1, 8'd2},
      {1'b0, 1'b0, 8'd12, 8'd4, 8'd9, 8'd1, 8'd3, 8'd1},
      {1'b1, 1'b1, 8'd1,  8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
      {1'b1, 1'b0, 8'd0,  8'd5, 8'd2, 8'd3, 8'd2, 8'd1},
      {1'b0, 1'b1, 8'd4,  8'd2, 8'd3, 8'd2, 8'd2, 8'd2},
      {1'b1, 1'b1, 8'd30, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic range_hi = 1'b1;
   logic in_pos = 1'b1;
   logic cmp_zero = 1'b0;
   logic sw_zi, sw_int1, sw_int2, sw_int, sw_de, sw_de_pos, sw_de_neg;
   logic sw_rest, sw_x10, cnt_en, cnt_up, offset_pass, ovr_flag, latch_n;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] tgt [0:5];
   logic cfg_rng = 1'b1;
   logic cfg_pos = 1'b1;

   int net = 0, pulses = 0, up_n = 0, k = 0, de_k = 0;
   int int1_w = 0, int2_w = 0, rest_w = 0, x10_w = 0, zi_w = 0, lat_w = 0;
   int pos_bad = 0, offs_bad = 0;
   logic lat_q = 1'b1;
   logic de_q = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   si_phase_seq #(
      .OSC_DIV(DIV), .INT_LEN_HI(IHI), .INT_LEN_LO(ILO), .REST_LEN(RST_L),
      .X10_LEN(X10_L), .ZI_LEN(ZI_L), .LATCH_LEN(LAT_L), .DE_TIMEOUT(TO)
   ) i_si_phase_seq (
      .clk(clk), .rst_n(rst_n), .range_hi(range_hi), .in_pos(in_pos),
      .cmp_zero(cmp_zero), .sw_zi(sw_zi), .sw_int1(sw_int1), .sw_int2(sw_int2),
      .sw_int(sw_int), .sw_de(sw_de), .sw_de_pos(sw_de_pos), .sw_de_neg(sw_de_neg),
      .sw_rest(sw_rest), .sw_x10(sw_x10), .cnt_en(cnt_en), .cnt_up(cnt_up),
      .offset_pass(offset_pass), .ovr_flag(ovr_flag), .latch_n(latch_n)
   );

   // integrator/comparator model and statistics, evaluated at the falling edge
   always @(negedge clk) begin
      if (latch_n && !lat_q) begin
         net = 0; pulses = 0; up_n = 0; k = 0; de_k = 0;
         int1_w = 0; int2_w = 0; rest_w = 0; x10_w = 0; zi_w = 0;
         pos_bad = 0; offs_bad = 0;
      end
      if (!latch_n && lat_q) lat_w = 0;
      if (!latch_n) lat_w++;
      lat_q = latch_n;
      if (sw_int1) int1_w++;
      if (sw_int2) int2_w++;
      if ((sw_int1 && offset_pass) || (sw_int2 && !offset_pass)) offs_bad++;
      if (sw_rest) rest_w++;
      if (sw_x10) x10_w++;
      if (sw_zi) zi_w++;
      cmp_zero = 1'b0;
      if (!sw_de) begin
         if (sw_de_pos != cfg_pos || sw_de_neg == cfg_pos) pos_bad++;
         if (cnt_en) begin
            k++;
            pulses++;
            if (cnt_up) begin net++; up_n++; end
            else net--;
            if (de_k < 6 && tgt[de_k] != 8'd0 && k == int'(tgt[de_k])) cmp_zero = 1'b1;
         end
         de_q = 1'b1;
      end else begin
         if (de_q) begin de_k++; k = 0; end
         de_q = 1'b0;
         if (sw_de_pos || sw_de_neg) pos_bad++;
         if (cnt_en) pos_bad++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(input logic [49:0] v);
      cfg_rng = v[49];
      cfg_pos = v[48];
      range_hi = v[49];
      in_pos = v[48];
      for (int j = 0; j < 6; j++) tgt[j] = v[47-8*j -: 8];
   endtask

   task automatic wait_latch_fall();
      do @(negedge clk); while (latch_n);
      #1;
   endtask

   task automatic wait_latch_rise();
      do @(negedge clk); while (!latch_n);
      #1;
   endtask

   task automatic check_conv(input int idx);
      int e_net = 0, e_pul = 0, e_up = 0, e_ovr = 0, c, s;
      for (int j = 0; j < 6; j++) begin
         c = (tgt[j] == 8'd0) ? TO : int'(tgt[j]);
         if (tgt[j] == 8'd0) e_ovr = 1;
         // input pass: up, down, up; offset pass: down, up, down
         s = (j < 3) ? ((j == 1) ? -1 : 1) : ((j == 4) ? 1 : -1);
         e_net += s * c;
         e_pul += c;
         if (s > 0) e_up += c;
      end
      $display("conversion %0d: net=%0d ovr=%0b", idx, net, ovr_flag);
      chk("R1 de phase count", de_k, 6);
      chk("R2 input integrate width", int1_w, DIV * (cfg_rng ? IHI : ILO));
      chk("R2 offset integrate width", int2_w, DIV * (cfg_rng ? IHI : ILO));
      chk("R3 R4 count pulses", pulses, e_pul);
      chk("R4 net count", net, e_net);
      chk("R5 up pulses", up_n, e_up);
      chk("R5 offset_pass marking", offs_bad, 0);
      chk("R6 ovr_flag", int'(ovr_flag), e_ovr);
      chk("R7 polarity switches", pos_bad, 0);
      chk("R9 rest width", rest_w, 4 * RST_L * DIV);
      chk("R9 x10 width", x10_w, 4 * X10_L * DIV);
      chk("R9 zi width", zi_w, ZI_L * DIV);
   endtask

   initial begin
      for (int j = 0; j < 6; j++) tgt[j] = 8'd1;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      // R11 reset state
      chk("R11 sw_zi", int'(sw_zi), 1);
      chk("R11 sw_int", int'(sw_int), 1);
      chk("R11 sw_de", int'(sw_de), 1);
      chk("R11 cnt_en", int'(cnt_en), 0);
      chk("R11 latch_n", int'(latch_n), 1);
      chk("R11 ovr_flag", int'(ovr_flag), 0);
      chk("R11 offset_pass", int'(offset_pass), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      wait_latch_fall();
      for (int v = 0; v < NV; v++) begin
         load(VEC[v]);
         wait_latch_rise();
         chk("R10 latch strobe width", lat_w, LAT_L * DIV);
         wait_latch_fall();
         check_conv(v);
      end
      // R2 range flipped in the middle of the input integrate
      load({1'b1, 1'b0, 8'd6, 8'd2, 8'd3, 8'd1, 8'd2, 8'd1});
      wait_latch_rise();
      chk("R10 latch strobe width", lat_w, LAT_L * DIV);
      do @(negedge clk); while (!sw_int1);
      #1;
      range_hi = 1'b0;
      wait_latch_fall();
      check_conv(NV);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule